// File: doc/BRIEF.md
# Banked Memory Decoder with Environment Register

This block sits between the address bus of an 8-bit processor and the memory system. It takes the 16-bit CPU address and the read and write strobes, and drives one physical target per access: a system-bank RAM address with chip enable and write enable, a ROM select, an I/O select, or an open-bus indication. An open-bus read means the data bus floats to 0xFF.

An 8-bit environment register, loaded from the CPU write data on a clock edge while its load strobe is high, controls the decode:

- bit 7 (`slow`) selects the CPU clock rate.
- bit 6 (`io_en`) exposes the I/O page and hides the slot RAM windows.
- bit 3 (`wp`) blocks RAM writes anywhere at or above C000.
- bit 0 (`rom_en`) overlays ROM on reads of the top 4 KB.

The remaining bits (5 video, 4 NMI, 2 stack, 1 primary ROM) are only stored and presented to neighbouring blocks. Writes to the top 4 KB always land in the RAM under the overlay unless write protection is on.

The decode is combinational and has two internal steps. First, an ascending comparison chain assigns the address to one of seven named regions:

| Region | Addresses |
|---|---|
| `RGN_LOW` | below C000 |
| `RGN_IOPAGE` | C000–C0FF |
| `RGN_SLOT` | C100–C4FF |
| `RGN_SHARED` | C500–C7FF |
| `RGN_EXPAN` | C800–CFFF |
| `RGN_MAIN` | D000–EFFF |
| `RGN_TOP` | F000–FFFF |

Second, a target selector picks one of five named targets: `TGT_NONE`, `TGT_RAM`, `TGT_ROM`, `TGT_IO` and `TGT_OPEN`. The transition to each target is a function of the region, the strobes and the environment bits. The only clocked state is the environment register.

Top module: `bank_mem_decoder`

## Requirements
- R1: After reset the environment register reads 0xFF on `env_bits`, so `speed_slow` is 1 and I/O enable, write protect and ROM enable are all set.
- R2: On a rising clock edge with `env_ld` high, `env_bits` takes the value of `cpu_wdata`. With `env_ld` low, `env_bits` holds its value.
- R3: `speed_slow` equals environment bit 7. A value of 1 requests 1 MHz and a value of 0 requests 2 MHz.
- R4: An access below C000 drives `ram_ce` with `ram_addr` equal to `cpu_addr`, and `ram_we` equal to the write strobe. The write-protect bit (bit 3) has no effect there.
- R5: With bit 6 set, any access to C000–C0FF asserts only `io_sel`.
- R6: With bit 6 clear, an access to C000–C0FF goes to RAM at 0x4000 plus the low address byte.
- R7: With bit 6 clear, C100–C4FF and C800–CFFF go to RAM at the CPU address minus 0x8000. With bit 6 set, a read there asserts only `open_bus` and a write asserts nothing.
- R8: C500–C7FF go to RAM at the CPU address minus 0x8000 (0x4500 upward), whatever the value of bit 6.
- R9: D000–EFFF go to RAM at the CPU address minus 0x8000 (0x5000 upward).
- R10: A read of F000–FFFF asserts `rom_sel` when bit 0 is set, and otherwise reads RAM at the CPU address minus 0x8000 (0x7000 upward). Write protect has no effect on reads.
- R11: A write to F000–FFFF with bit 3 clear goes to RAM at 0x7000 upward, whether or not bit 0 is set.
- R12: With bit 3 set, a write anywhere in C000–FFFF drives neither `ram_ce` nor `ram_we`. RAM reads in that range are unaffected.
- R13: With both strobes low, `ram_ce`, `ram_we`, `rom_sel`, `io_sel`, `open_bus` and `ram_addr` are all zero. If both strobes are high, the access is treated as a write.
- R14: At most one of `ram_ce`, `rom_sel`, `io_sel` and `open_bus` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | CPU write data, loaded into the environment register |
| env_ld | input | 1 | Environment register load strobe |
| ram_addr | output | 16 | Physical system-bank RAM address, zero when RAM is not selected |
| ram_ce | output | 1 | RAM chip enable |
| ram_we | output | 1 | RAM write enable |
| rom_sel | output | 1 | ROM select |
| io_sel | output | 1 | I/O page select |
| open_bus | output | 1 | Read of a hidden window; data bus reads 0xFF |
| speed_slow | output | 1 | 1 requests 1 MHz, 0 requests 2 MHz |
| env_bits | output | 8 | Current environment register value |

## Verification
The assertions check the invariants that hold on every cycle:

- at most one target is selected at a time;
- a RAM write enable is always accompanied by a chip enable and a write strobe;
- write protection never lets a write through at or above C000;
- ROM and open bus appear only on reads of their own windows;
- the quiet state holds when no strobe is present;
- the environment register loads and holds correctly.

The physical address offsets of each window need the bench's scenarios, which walk every boundary address under chosen environment values. So do the read/write asymmetry of the top 4 KB and the visibility switch of the slot windows.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // environment register bit positions
    localparam int ENV_SLOW   = 7;
    localparam int ENV_IOEN   = 6;
    localparam int ENV_WP     = 3;
    localparam int ENV_ROMEN  = 0;
    localparam logic [DATA_W-1:0] ENV_RESET = 8'hFF;

    // region start addresses (ascending)
    localparam logic [ADDR_W-1:0] IOPAGE_LO = 16'hC000;
    localparam logic [ADDR_W-1:0] SLOT_LO   = 16'hC100;
    localparam logic [ADDR_W-1:0] SHARED_LO = 16'hC500;
    localparam logic [ADDR_W-1:0] EXPAN_LO  = 16'hC800;
    localparam logic [ADDR_W-1:0] MAIN_LO   = 16'hD000;
    localparam logic [ADDR_W-1:0] TOP_LO    = 16'hF000;

    // physical bases in the system bank
    localparam logic [ADDR_W-1:0] IOPAGE_PB = 16'h4000;
    localparam logic [ADDR_W-1:0] SLOT_PB   = 16'h4100;
    localparam logic [ADDR_W-1:0] SHARED_PB = 16'h4500;
    localparam logic [ADDR_W-1:0] EXPAN_PB  = 16'h4800;
    localparam logic [ADDR_W-1:0] MAIN_PB   = 16'h5000;
    localparam logic [ADDR_W-1:0] TOP_PB    = 16'h7000;

    typedef enum logic [2:0] {
        RGN_LOW,
        RGN_IOPAGE,
        RGN_SLOT,
        RGN_SHARED,
        RGN_EXPAN,
        RGN_MAIN,
        RGN_TOP
    } region_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_RAM,
        TGT_ROM,
        TGT_IO,
        TGT_OPEN
    } target_e;

endpackage

// File: rtl/bmd_env_reg.sv
module bmd_env_reg
    import bmd_pkg::*;
#(
    parameter int                W         = DATA_W,
    parameter logic [W-1:0]      RESET_VAL = ENV_RESET
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else if (ld) begin
            q <= d;
        end
    end

    // R2: a load takes the data presented on the strobe cycle
    assert_env_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (q == $past(d)));

    // R2: without a strobe the value is held
    assert_env_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(q));

endmodule

// File: rtl/bmd_region_decode.sv
module bmd_region_decode
    import bmd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [ADDR_W-1:0] phys
);

    logic [ADDR_W-1:0] rgn_lo;
    logic [ADDR_W-1:0] rgn_pb;

    // ascending compare chain: each address falls into exactly one region
    always_comb begin
        if (addr < IOPAGE_LO) begin
            region = RGN_LOW;
            rgn_lo = '0;
            rgn_pb = '0;
        end else if (addr < SLOT_LO) begin
            region = RGN_IOPAGE;
            rgn_lo = IOPAGE_LO;
            rgn_pb = IOPAGE_PB;
        end else if (addr < SHARED_LO) begin
            region = RGN_SLOT;
            rgn_lo = SLOT_LO;
            rgn_pb = SLOT_PB;
        end else if (addr < EXPAN_LO) begin
            region = RGN_SHARED;
            rgn_lo = SHARED_LO;
            rgn_pb = SHARED_PB;
        end else if (addr < MAIN_LO) begin
            region = RGN_EXPAN;
            rgn_lo = EXPAN_LO;
            rgn_pb = EXPAN_PB;
        end else if (addr < TOP_LO) begin
            region = RGN_MAIN;
            rgn_lo = MAIN_LO;
            rgn_pb = MAIN_PB;
        end else begin
            region = RGN_TOP;
            rgn_lo = TOP_LO;
            rgn_pb = TOP_PB;
        end
    end

    assign phys = rgn_pb + (addr - rgn_lo);

endmodule

// File: rtl/bmd_route.sv
module bmd_route
    import bmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  region_e           region,
    input  logic [ADDR_W-1:0] phys,
    input  logic              rd,
    input  logic              wr,
    input  logic              io_en,
    input  logic              wp,
    input  logic              rom_en,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_ce,
    output logic              ram_we,
    output logic              rom_sel,
    output logic              io_sel,
    output logic              open_bus
);

    logic    is_wr;
    logic    is_rd;
    target_e tgt;
    target_e ram_path;

    assign is_wr = wr;
    assign is_rd = rd & ~wr;

    // upper-region RAM path: writes gated by write protect
    always_comb begin
        if (is_wr) begin
            ram_path = wp ? TGT_NONE : TGT_RAM;
        end else if (is_rd) begin
            ram_path = TGT_RAM;
        end else begin
            ram_path = TGT_NONE;
        end
    end

    // target selection
    always_comb begin
        tgt = TGT_NONE;
        unique case (region)
            RGN_LOW: begin
                tgt = (is_rd | is_wr) ? TGT_RAM : TGT_NONE;
            end
            RGN_IOPAGE: begin
                if (io_en) begin
                    tgt = (is_rd | is_wr) ? TGT_IO : TGT_NONE;
                end else begin
                    tgt = ram_path;
                end
            end
            RGN_SLOT, RGN_EXPAN: begin
                if (io_en) begin
                    tgt = is_rd ? TGT_OPEN : TGT_NONE;
                end else begin
                    tgt = ram_path;
                end
            end
            RGN_SHARED, RGN_MAIN: begin
                tgt = ram_path;
            end
            RGN_TOP: begin
                if (is_rd && rom_en) begin
                    tgt = TGT_ROM;
                end else begin
                    tgt = ram_path;
                end
            end
            default: tgt = TGT_NONE;
        endcase
    end

    // output decode
    always_comb begin
        ram_ce   = 1'b0;
        ram_we   = 1'b0;
        rom_sel  = 1'b0;
        io_sel   = 1'b0;
        open_bus = 1'b0;
        ram_addr = '0;
        unique case (tgt)
            TGT_RAM: begin
                ram_ce   = 1'b1;
                ram_we   = is_wr;
                ram_addr = phys;
            end
            TGT_ROM:  rom_sel  = 1'b1;
            TGT_IO:   io_sel   = 1'b1;
            TGT_OPEN: open_bus = 1'b1;
            default: ;
        endcase
    end

    // R14: never more than one target
    assert_one_target_R14: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_ce, rom_sel, io_sel, open_bus}));

    // R12: a RAM write needs a chip enable and a write strobe
    assert_we_with_ce_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_ce && wr));

    // R12: write protect blocks every write above the low region
    assert_wp_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wp && wr && region != RGN_LOW) |-> (!ram_we && !ram_ce));

    // R13: quiet when no strobe is present
    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && !wr) |-> (!ram_ce && !rom_sel && !io_sel && !open_bus && ram_addr == '0));

    // R10: ROM only on reads of the top region
    assert_rom_read_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (rd && !wr && region == RGN_TOP));

    // R7: open bus only on reads of a hidden slot window
    assert_open_read_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        open_bus |-> (rd && !wr && io_en && (region == RGN_SLOT || region == RGN_EXPAN)));

endmodule

// File: rtl/bank_mem_decoder.sv
module bank_mem_decoder
    import bmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [7:0]        cpu_wdata,
    input  logic              env_ld,
    output logic [15:0]       ram_addr,
    output logic              ram_ce,
    output logic              ram_we,
    output logic              rom_sel,
    output logic              io_sel,
    output logic              open_bus,
    output logic              speed_slow,
    output logic [7:0]        env_bits
);

    logic [DATA_W-1:0] env_q;
    region_e           region;
    logic [ADDR_W-1:0] phys;

    bmd_env_reg #(
        .W         (DATA_W),
        .RESET_VAL (ENV_RESET)
    ) env_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (env_ld),
        .d     (cpu_wdata),
        .q     (env_q)
    );

    bmd_region_decode rgn_i (
        .addr   (cpu_addr),
        .region (region),
        .phys   (phys)
    );

    bmd_route route_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .region   (region),
        .phys     (phys),
        .rd       (cpu_rd),
        .wr       (cpu_wr),
        .io_en    (env_q[ENV_IOEN]),
        .wp       (env_q[ENV_WP]),
        .rom_en   (env_q[ENV_ROMEN]),
        .ram_addr (ram_addr),
        .ram_ce   (ram_ce),
        .ram_we   (ram_we),
        .rom_sel  (rom_sel),
        .io_sel   (io_sel),
        .open_bus (open_bus)
    );

    assign speed_slow = env_q[ENV_SLOW];
    assign env_bits   = env_q;

    // R8: the shared window is RAM for every read regardless of I/O enable
    assert_shared_ram_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && cpu_addr >= SHARED_LO && cpu_addr < EXPAN_LO) |-> ram_ce);

endmodule

// File: tb/bank_mem_decoder_tb_top.sv
module bank_mem_decoder_tb_top;

    typedef struct packed {
        logic [7:0]  env;
        logic [15:0] addr;
        logic        rd;
        logic        wr;
        logic [15:0] xa;
        logic        xce;
        logic        xwe;
        logic        xrom;
        logic        xio;
        logic        xob;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    // env, addr, rd, wr, exp ram_addr, ce, we, rom, io, open, requirement
    localparam vec_t VECS [NV] = '{
        '{8'h00, 16'h1234, 1'b1, 1'b0, 16'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
        '{8'hFF, 16'hBFFF, 1'b0, 1'b1, 16'hBFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 wp ignored
        '{8'hFF, 16'hC000, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5},  // R5
        '{8'h40, 16'hC0FF, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5},  // R5
        '{8'h00, 16'hC0A5, 1'b1, 1'b0, 16'h40A5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
        '{8'h00, 16'hC012, 1'b0, 1'b1, 16'h4012, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
        '{8'h08, 16'hC012, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd12}, // R12
        '{8'h00, 16'hC100, 1'b1, 1'b0, 16'h4100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{8'h00, 16'hC4FF, 1'b0, 1'b1, 16'h44FF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{8'h40, 16'hC234, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7},  // R7
        '{8'h40, 16'hC900, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{8'h00, 16'hCFFF, 1'b1, 1'b0, 16'h4FFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{8'h40, 16'hC500, 1'b1, 1'b0, 16'h4500, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8
        '{8'h40, 16'hC7FF, 1'b0, 1'b1, 16'h47FF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8},  // R8
        '{8'h48, 16'hC600, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd12}, // R12
        '{8'h00, 16'hD000, 1'b0, 1'b1, 16'h5000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
        '{8'h00, 16'hEFFF, 1'b1, 1'b0, 16'h6FFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
        '{8'h01, 16'hF000, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd10}, // R10
        '{8'h00, 16'hFFFF, 1'b1, 1'b0, 16'h7FFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
        '{8'h01, 16'hF123, 1'b0, 1'b1, 16'h7123, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd11}, // R11
        '{8'h09, 16'hF123, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd12}, // R12
        '{8'h09, 16'hFFFE, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd10}, // R10
        '{8'h08, 16'hE000, 1'b1, 1'b0, 16'h6000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd12}, // R12 reads pass
        '{8'hFF, 16'h8000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd13}, // R13
        '{8'h00, 16'hD000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd13}  // R13
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic        env_ld = 1'b0;
    logic [15:0] ram_addr;
    logic        ram_ce, ram_we, rom_sel, io_sel, open_bus, speed_slow;
    logic [7:0]  env_bits;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    bank_mem_decoder dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .cpu_wdata  (cpu_wdata),
        .env_ld     (env_ld),
        .ram_addr   (ram_addr),
        .ram_ce     (ram_ce),
        .ram_we     (ram_we),
        .rom_sel    (rom_sel),
        .io_sel     (io_sel),
        .open_bus   (open_bus),
        .speed_slow (speed_slow),
        .env_bits   (env_bits)
    );

    task automatic check(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic load_env(input logic [7:0] v);
        @(negedge clk);
        cpu_wdata = v;
        env_ld    = 1'b1;
        @(negedge clk);
        env_ld    = 1'b0;
        cpu_wdata = 8'h00;
    endtask

    task automatic access(input logic [15:0] a, input logic r, input logic w);
        @(negedge clk);
        cpu_addr = a;
        cpu_rd   = r;
        cpu_wr   = w;
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("env after reset", 1, 32'(env_bits), 32'hFF);
        check("speed after reset", 1, 32'(speed_slow), 32'h1);
        access(16'hF000, 1'b1, 1'b0);
        check("rom overlay after reset", 1, 32'(rom_sel), 32'h1);

        // R2: load and hold
        load_env(8'h5A);
        #1;
        check("env load", 2, 32'(env_bits), 32'h5A);
        @(negedge clk);
        cpu_wdata = 8'hC3;
        @(negedge clk);
        #1;
        check("env hold without strobe", 2, 32'(env_bits), 32'h5A);
        cpu_wdata = 8'h00;

        // R3: speed select
        load_env(8'h80);
        #1;
        check("slow speed", 3, 32'(speed_slow), 32'h1);
        load_env(8'h7F);
        #1;
        check("fast speed", 3, 32'(speed_slow), 32'h0);

        // vector table: R4..R14 (R14 through the all-output comparison)
        for (int i = 0; i < NV; i++) begin
            load_env(VECS[i].env);
            access(VECS[i].addr, VECS[i].rd, VECS[i].wr);
            check($sformatf("v%0d ram_addr", i), int'(VECS[i].req), 32'(ram_addr), 32'(VECS[i].xa));
            check($sformatf("v%0d selects", i), int'(VECS[i].req),
                  32'({ram_ce, ram_we, rom_sel, io_sel, open_bus}),
                  32'({VECS[i].xce, VECS[i].xwe, VECS[i].xrom, VECS[i].xio, VECS[i].xob}));
        end

        // R13: both strobes treated as a write
        load_env(8'h01);
        access(16'hF010, 1'b1, 1'b1);
        check("both strobes write", 13, 32'({ram_ce, ram_we, rom_sel}), 32'b110);
        check("both strobes addr", 13, 32'(ram_addr), 32'h7010);

        // R1: asynchronous reset restores 0xFF
        access(16'h0000, 1'b0, 1'b0);
        rst_n = 1'b0;
        #1;
        check("env on reset", 1, 32'(env_bits), 32'hFF);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule